// File: doc/BRIEF.md
# Sixteen-Bit Single-Cycle Instruction-Word Core

This block is a small processor core that completes one instruction per clock. It keeps three registers: an address/value register, a data register and a program counter. The instruction word and the data-memory read word arrive on input ports from memories outside the block. The core presents a write strobe, a write value and a memory address, and it exposes the program counter so the instruction memory can be indexed.

A word whose three top bits are all ones is a compute word. Its lower fields configure the ALU operands, the ALU function and the destinations, and give a three-bit jump mask that is tested against the sign and zero flags of the result. Any other word is a literal and is copied whole into the address register. The ALU result and the address are combinational, so the memory sees them in the same cycle as the instruction. Reset is synchronous and returns only the program counter to zero.

Top module: `hcore16`

## Requirements
- R1: A word with bits [15:13] not all ones loads its full 16-bit value into the address register. It leaves the data register unchanged, holds the write strobe low and never jumps, so the PC advances by one.
- R2: The first ALU operand is the data register. Bit 11 clears it to zero, then bit 10 inverts it, so when both bits are set the operand is all ones.
- R3: The second operand is the data-memory read word when bit 12 is 1 and the address register when bit 12 is 0. Bit 9 then clears it and bit 8 inverts it.
- R4: Bit 7 selects the sum modulo 2^16 (1) or the bitwise AND (0) of the two shaped operands, and bit 6 inverts that value to give the result.
- R5: On a compute word, bit 5 writes the result into the address register, bit 4 writes it into the data register and bit 3 raises the write strobe. The strobe is always low for literal words.
- R6: Let the flag code be 3'b100 when the result is negative (bit 15 = 1), 3'b010 when the result is zero, and 3'b001 otherwise. A compute word jumps when its bits [2:0] share a set bit with that code. A jump loads the PC with the address register value from before this cycle's update.
- R7: On a rising edge with reset high the PC becomes 0. Otherwise, when no jump is taken, it becomes PC+1, and 0xFFFF wraps to 0x0000.
- R8: The write value output is the current ALU result and the address output is the current address register value, both combinational in the cycle of the instruction.
- R9: Reset affects only the PC. The address and data registers keep their values and still accept writes from the instruction presented during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset of the program counter |
| instr_i | input | 16 | Instruction word for this cycle |
| data_rd_i | input | 16 | Word read from data memory |
| data_wr_o | output | 16 | ALU result, the value to store |
| data_we_o | output | 1 | Data-memory write strobe |
| data_addr_o | output | 16 | Address register, the data-memory address |
| pc_o | output | 16 | Program counter |

## Verification
The assertions assume the instruction and read-data inputs hold known values in each cycle, and that reset is high on the first clock edge so that no past-value comparison reaches back before a defined PC. Both working registers start undefined. The stimulus therefore writes the address register and the data register through ordinary instructions before any check that depends on them. It also changes inputs only on the falling edge, so every sampled output has settled.

// File: rtl/core16_pkg.sv
package core16_pkg;

  localparam int unsigned WORD_W  = 16;
  localparam int unsigned CLASS_W = 3;
  localparam int unsigned JMASK_W = 3;

  // instruction field positions (the encoding is behaviour)
  localparam int unsigned F_CLASS_LO = WORD_W - CLASS_W;
  localparam int unsigned F_MEMSEL   = 12;
  localparam int unsigned F_ZX       = 11;
  localparam int unsigned F_NX       = 10;
  localparam int unsigned F_ZY       = 9;
  localparam int unsigned F_NY       = 8;
  localparam int unsigned F_ADD      = 7;
  localparam int unsigned F_NOUT     = 6;
  localparam int unsigned F_DST_A    = 5;
  localparam int unsigned F_DST_D    = 4;
  localparam int unsigned F_DST_M    = 3;

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [JMASK_W-1:0] jmask_t;

  typedef struct packed {
    logic sel_mem;
    logic clr_x;
    logic inv_x;
    logic clr_y;
    logic inv_y;
    logic use_add;
    logic inv_out;
  } alu_op_t;

  function automatic logic is_compute(word_t w);
    return &w[WORD_W-1:F_CLASS_LO];
  endfunction

  // clear first, then invert
  function automatic word_t shape(word_t v, logic clr, logic inv);
    word_t t;
    t = clr ? '0 : v;
    return t ^ {WORD_W{inv}};
  endfunction

  function automatic word_t combine(word_t x, word_t y, logic add, logic inv);
    word_t t;
    t = add ? word_t'(x + y) : (x & y);
    return inv ? ~t : t;
  endfunction

  function automatic logic jump_hit(jmask_t m, logic z, logic n);
    jmask_t code;
    code = {n, z, ~(n | z)};
    return |(m & code);
  endfunction

endpackage

// File: rtl/core16_decode.sv
module core16_decode
  import core16_pkg::*;
(
  input  word_t   instr,
  output logic    calc,
  output alu_op_t alu_op,
  output logic    dst_a,
  output logic    dst_d,
  output logic    dst_m,
  output jmask_t  jmask,
  output word_t   literal
);

  always_comb begin
    calc            = is_compute(instr);
    alu_op.sel_mem  = instr[F_MEMSEL];
    alu_op.clr_x    = instr[F_ZX];
    alu_op.inv_x    = instr[F_NX];
    alu_op.clr_y    = instr[F_ZY];
    alu_op.inv_y    = instr[F_NY];
    alu_op.use_add  = instr[F_ADD];
    alu_op.inv_out  = instr[F_NOUT];
    dst_a           = instr[F_DST_A];
    dst_d           = instr[F_DST_D];
    dst_m           = instr[F_DST_M];
    jmask           = instr[JMASK_W-1:0];
    literal         = instr;
  end

endmodule

// File: rtl/core16_alu.sv
module core16_alu
  import core16_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  alu_op_t op,
  input  word_t   d_val,
  input  word_t   a_val,
  input  word_t   m_val,
  output word_t   result,
  output logic    zero,
  output logic    neg
);

  word_t raw    [LANES];
  logic  clr    [LANES];
  logic  inv    [LANES];
  word_t shaped [LANES];

  always_comb begin
    raw[0] = d_val;
    clr[0] = op.clr_x;
    inv[0] = op.inv_x;
    raw[1] = op.sel_mem ? m_val : a_val;
    clr[1] = op.clr_y;
    inv[1] = op.inv_y;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign shaped[g] = shape(raw[g], clr[g], inv[g]);
  end

  assign result = combine(shaped[0], shaped[1], op.use_add, op.inv_out);
  assign zero   = (result == '0);
  assign neg    = result[WORD_W-1];

endmodule

// File: rtl/core16_branch.sv
module core16_branch
  import core16_pkg::*;
(
  input  logic   calc,
  input  jmask_t jmask,
  input  logic   zero,
  input  logic   neg,
  output logic   take
);

  assign take = calc & jump_hit(jmask, zero, neg);

endmodule

// File: rtl/core16_state.sv
module core16_state
  import core16_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  calc,
  input  logic  dst_a,
  input  logic  dst_d,
  input  word_t literal,
  input  word_t result,
  input  logic  take,
  output word_t a_q,
  output word_t d_q,
  output word_t pc_q
);

  logic  a_en;
  logic  d_en;
  word_t a_next;
  word_t pc_next;

  always_comb begin
    a_en    = ~calc | dst_a;
    a_next  = calc ? result : literal;
    d_en    = calc & dst_d;
    pc_next = take ? a_q : word_t'(pc_q + word_t'(1));
  end

  // working registers carry no reset
  always_ff @(posedge clk) begin
    if (a_en) a_q <= a_next;
    if (d_en) d_q <= result;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

endmodule

// File: rtl/hcore16.sv
module hcore16
  import core16_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] instr_i,
  input  logic [15:0] data_rd_i,
  output logic [15:0] data_wr_o,
  output logic        data_we_o,
  output logic [15:0] data_addr_o,
  output logic [15:0] pc_o
);

  logic    calc;
  alu_op_t alu_op;
  logic    dst_a;
  logic    dst_d;
  logic    dst_m;
  jmask_t  jmask;
  word_t   literal;
  word_t   alu_res;
  logic    flag_z;
  logic    flag_n;
  logic    take_jump;
  word_t   a_q;
  word_t   d_q;
  word_t   pc_q;

  core16_decode u_dec (
    .instr   (instr_i),
    .calc    (calc),
    .alu_op  (alu_op),
    .dst_a   (dst_a),
    .dst_d   (dst_d),
    .dst_m   (dst_m),
    .jmask   (jmask),
    .literal (literal)
  );

  core16_alu #(.LANES(2)) u_alu (
    .op     (alu_op),
    .d_val  (d_q),
    .a_val  (a_q),
    .m_val  (data_rd_i),
    .result (alu_res),
    .zero   (flag_z),
    .neg    (flag_n)
  );

  core16_branch u_br (
    .calc  (calc),
    .jmask (jmask),
    .zero  (flag_z),
    .neg   (flag_n),
    .take  (take_jump)
  );

  core16_state u_st (
    .clk     (clk),
    .rst     (rst),
    .calc    (calc),
    .dst_a   (dst_a),
    .dst_d   (dst_d),
    .literal (literal),
    .result  (alu_res),
    .take    (take_jump),
    .a_q     (a_q),
    .d_q     (d_q),
    .pc_q    (pc_q)
  );

  assign data_wr_o   = alu_res;
  assign data_we_o   = calc & dst_m;
  assign data_addr_o = a_q;
  assign pc_o        = pc_q;

endmodule

// File: rtl/core16_chk.sv
module core16_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] instr_i,
  input logic [15:0] data_addr_o,
  input logic        data_we_o,
  input logic [15:0] pc_o,
  input logic        calc,
  input logic        take_jump,
  input logic        flag_z,
  input logic        flag_n
);

  logic rst_q = 1'b0;
  logic seen  = 1'b0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    seen  <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (seen && rst_q) begin
      // R7
      reset_pc_chk: assert (pc_o == 16'h0000)
        else $error("pc not cleared by reset");
    end
  end

  // R1
  literal_load_chk: assert property (@(posedge clk) disable iff (rst)
    !calc |=> data_addr_o == $past(instr_i));

  // R1
  literal_nojump_chk: assert property (@(posedge clk) disable iff (rst)
    !calc |-> !take_jump);

  // R5
  literal_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    !calc |-> !data_we_o);

  // R6
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    take_jump |=> pc_o == $past(data_addr_o));

  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(flag_z && flag_n));

  // R7
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !take_jump |=> pc_o == 16'($past(pc_o) + 16'd1));

endmodule

bind hcore16 core16_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .instr_i     (instr_i),
  .data_addr_o (data_addr_o),
  .data_we_o   (data_we_o),
  .pc_o        (pc_o),
  .calc        (calc),
  .take_jump   (take_jump),
  .flag_z      (flag_z),
  .flag_n      (flag_n)
);

// File: tb/sim_hcore16.sv
module sim_hcore16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr = 16'h0000;
  logic [15:0] rd = 16'h0000;
  logic [15:0] wr;
  logic        we;
  logic [15:0] addr;
  logic [15:0] pc;

  int n_chk  = 0;
  int n_fail = 0;

  logic [15:0] mA = 0, mD = 0, mPC = 0;
  bit kA = 0, kD = 0, kPC = 0;

  hcore16 u0 (
    .clk(clk), .rst(rst), .instr_i(instr), .data_rd_i(rd),
    .data_wr_o(wr), .data_we_o(we), .data_addr_o(addr), .pc_o(pc)
  );

  always #5 clk = ~clk;

  function automatic logic [15:0] ref_res(logic [15:0] w, logic [15:0] dv,
                                          logic [15:0] av, logic [15:0] mv);
    logic [15:0] x, y, r;
    x = dv;
    if (w[11]) x = 16'h0000;
    if (w[10]) x = 16'hFFFF - x;
    y = w[12] ? mv : av;
    if (w[9]) y = 16'h0000;
    if (w[8]) y = 16'hFFFF - y;
    r = w[7] ? ((x + y) % 17'h10000) : (x & y);
    if (w[6]) r = 16'hFFFF - r;
    return r;
  endfunction

  task automatic step(input logic [15:0] w, input logic [15:0] m,
                      input logic r, input string tag);
    logic [15:0] er;
    bit comp, jt;
    bit ewe;
    @(negedge clk);
    instr = w; rd = m; rst = r;
    #1;
    comp = (w[15:13] == 3'b111);
    er   = ref_res(w, mD, mA, m);
    ewe  = comp && w[3];
    if (kPC && kA) begin
      n_chk++;
      if (pc !== mPC || addr !== mA || we !== ewe || (kD && wr !== er)) begin
        n_fail++;
        $display("FAIL %s: pc=%h/%h addr=%h/%h we=%b/%b out=%h/%h (actual/expected)",
                 tag, pc, mPC, addr, mA, we, ewe, wr, er);
      end
    end
    jt = 0;
    if (comp) begin
      if (er[15])            jt = w[2];
      else if (er == 16'h0)  jt = w[1];
      else                   jt = w[0];
    end
    if (r)       begin mPC = 16'h0000; kPC = 1; end
    else if (jt) mPC = mA;
    else         mPC = mPC + 16'd1;
    if (comp) begin
      if (w[4]) begin mD = er; kD = 1; end
      if (w[5]) mA = er;
    end else begin
      mA = w; kA = 1;
    end
  endtask

  // out=A is c=110000, out=~A is c=110001; dest bits: A=100, D=010
  task automatic set_reg(input logic [15:0] v, input bit to_d, input string tag);
    logic [2:0] dst;
    dst = to_d ? 3'b010 : 3'b100;
    if (v[15:13] != 3'b111) begin
      step(v, 16'h0, 1'b0, tag);
      if (to_d) step({3'b111, 1'b0, 6'b110000, dst, 3'b000}, 16'h0, 1'b0, tag);
    end else begin
      step(~v, 16'h0, 1'b0, tag);
      step({3'b111, 1'b0, 6'b110001, dst, 3'b000}, 16'h0, 1'b0, tag);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  logic [15:0] pd [4] = '{16'h0000, 16'hFFFF, 16'h1234, 16'h7FFF};
  logic [15:0] pa [4] = '{16'h0000, 16'h0001, 16'hABCD, 16'h7FFF};
  logic [15:0] pm [4] = '{16'hFFFF, 16'h8000, 16'h5A5A, 16'h0001};
  logic [15:0] jd [3] = '{16'hFFFB, 16'h0000, 16'h0007};

  initial begin
    // R7 R9: reset with literal loads, then release
    step(16'h0005, 16'h0, 1'b1, "R9");
    step(16'h0009, 16'h0, 1'b1, "R7");
    step(16'h0011, 16'h0, 1'b1, "R7");
    step(16'h0022, 16'h0, 1'b0, "R7");
    set_reg(16'h1234, 1'b1, "R5");

    // R2 R3 R4 R8: every ALU control code, both operand sources
    for (int p = 0; p < 4; p++) begin
      set_reg(pd[p], 1'b1, "R2");
      set_reg(pa[p], 1'b0, "R3");
      for (int c = 0; c < 64; c++)
        for (int a = 0; a < 2; a++)
          step({3'b111, a[0], c[5:0], 3'b000, 3'b000}, pm[p], 1'b0, "R2 R3 R4 R8");
    end

    // R5: each destination combination; follow-up shows A and D
    for (int dd = 0; dd < 8; dd++) begin
      set_reg(16'h0100, 1'b1, "R5");
      set_reg(16'h0023, 1'b0, "R5");
      step({3'b111, 1'b0, 6'b000010, dd[2:0], 3'b000}, 16'h0, 1'b0, "R5");
      step({3'b111, 1'b0, 6'b001100, 3'b000, 3'b000}, 16'h0, 1'b0, "R5");
    end

    // R6: every mask against negative, zero and positive results
    for (int j = 0; j < 8; j++)
      for (int s = 0; s < 3; s++) begin
        set_reg(jd[s], 1'b1, "R6");
        set_reg(16'h0040 + 16'(j * 3 + s), 1'b0, "R6");
        step({3'b111, 1'b0, 6'b001100, 3'b000, j[2:0]}, 16'h0, 1'b0, "R6");
        step(16'h0001, 16'h0, 1'b0, "R6");
      end

    // R1: literal words, including jump and write bits set
    step(16'h7FFF, 16'hFFFF, 1'b0, "R1");
    step(16'hC00F, 16'h1111, 1'b0, "R1");
    step(16'hAFFF, 16'h2222, 1'b0, "R1");
    step(16'hDFFF, 16'h3333, 1'b0, "R1");
    step(16'h0000, 16'h4444, 1'b0, "R1");

    // R7: PC wraps from 0xFFFF to 0
    set_reg(16'hFFFF, 1'b0, "R7");
    step({3'b111, 1'b0, 6'b101010, 3'b000, 3'b111}, 16'h0, 1'b0, "R7");
    step(16'h0003, 16'h0, 1'b0, "R7");
    step(16'h0004, 16'h0, 1'b0, "R7");

    // R9: compute writes A and D while reset is high
    set_reg(16'h0011, 1'b1, "R9");
    step({3'b111, 1'b0, 6'b011111, 3'b010, 3'b000}, 16'h0, 1'b1, "R9");
    step({3'b111, 1'b0, 6'b011111, 3'b110, 3'b111}, 16'h0, 1'b1, "R9");
    step({3'b111, 1'b0, 6'b001100, 3'b000, 3'b000}, 16'h0, 1'b0, "R9");
    step(16'h0002, 16'h0, 1'b0, "R9");

    finish_run();
  end

endmodule